// File: doc/BRIEF.md
# Majority-Gate Pair-Step Adder

This block adds two unsigned operands of even width N and returns the N-bit sum together with the carry out of the top bit. It is purely combinational and has no clock, so the result follows the operands within the same evaluation.

The carry logic is built only from three-input majority gates. Operand bits are grouped into pairs, starting at the least significant end. One module per pair moves the carry across both of its bit positions through a single majority gate. That gate combines two nested majority terms. Each term mixes the odd bit's operands with the even bit's generate or propagate.

Generate and propagate come from majority gates with one input tied low or high. Propagate is an inclusive OR here, not an exclusive OR. There is no carry input. The carry into bit 0 is zero, so the lowest pair has a reduced form that needs no propagate term.

Each sum bit is formed from two majority gates and one inverter, driven by the carry into the bit and the carry out of it. The longest path starts at a carry born in bit 0 and ends at the MSB sum. It passes N/2 + 3 majority gates and one inverter.

Top module: `maj_pair_adder`

## Requirements
- R1: For every pair of operands, {carry_o, sum_o} equals the unsigned sum op_a + op_b as an (N+1)-bit value.
- R2: The carry leaving a bit pair (2k, 2k+1) is 1 exactly when any of these holds: bit 2k+1 generates; bit 2k+1 propagates and bit 2k generates; or both bits propagate and the carry into bit 2k is 1. A lone generate at bit j (op_a = op_b = 1 << j) yields a result of 1 << (j+1).
- R3: The carry into an odd bit 2k+1 is 1 exactly when bit 2k generates, or bit 2k propagates with a carry into it. A single 1 at bit j added to all-ones yields sum_o = (1 << j) - 1 with carry_o = 1.
- R4: Each sum bit equals the exclusive OR of its two operand bits and its incoming carry. Operands whose ones never overlap, such as alternating 0101 and 1010 patterns, give all-ones with carry_o = 0.
- R5: The carry into bit 0 is zero: 0 + 0 gives sum_o = 0 and carry_o = 0.
- R6: A carry born at bit 0 travels the full width: all-ones + 1 gives sum_o = 0 and carry_o = 1.
- R7: All-ones + all-ones gives sum_o with every bit set except bit 0, and carry_o = 1.
- R8: At N = 4, op_a = 0101 and op_b = 0010 give sum_o = 0111 and carry_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| sum_o | output | N | Low N bits of the sum |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry born in bit 0 that must survive every pair module up to carry_o. Random operands almost never produce it at N = 32.

The stimulus forces this case directly with all-ones plus one. It then walks a single generate bit and a single added one across every position. This makes each pair module's outgoing carry and intermediate carry the deciding term in turn.

Widths 4 and 8 are also run over every operand pair. At those widths, every carry pattern the pair structure can see actually occurs.

// File: rtl/maj_adder_pkg.sv
`timescale 1ns/1ps
package maj_adder_pkg;

    // generate / propagate of one bit position
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // carries produced by one two-bit module
    typedef struct packed {
        logic hi;   // carry leaving the pair
        logic lo;   // carry into the odd bit of the pair
    } pair_carry_t;

    function automatic gp_t gp_of(input logic a, input logic b);
        gp_t r;
        r.g = a & b;
        r.p = a | b;
        return r;
    endfunction

    // lookahead sum-of-products form, used as an independent reference
    function automatic pair_carry_t cla_pair(input logic [1:0] a,
                                             input logic [1:0] b,
                                             input logic       c);
        gp_t lo;
        gp_t hi;
        pair_carry_t r;
        lo   = gp_of(a[0], b[0]);
        hi   = gp_of(a[1], b[1]);
        r.lo = lo.g | (lo.p & c);
        r.hi = hi.g | (hi.p & lo.g) | (hi.p & lo.p & c);
        return r;
    endfunction

    function automatic bit width_ok(input int unsigned n);
        return (n >= 2) && (n % 2 == 0);
    endfunction

endpackage

// File: rtl/maj3.sv
`timescale 1ns/1ps
module maj3 (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic m_o
);
    assign m_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
endmodule

// File: rtl/maj_pair_first.sv
`timescale 1ns/1ps
module maj_pair_first
    import maj_adder_pkg::*;
(
    input  logic [1:0] a_i,
    input  logic [1:0] b_i,
    output logic       c_mid_o,
    output logic       c_out_o
);
    logic g_lo;
    pair_carry_t exp_c;

    // carry-in is zero: no propagate needed for bit 0
    maj3 u_g_lo (.x_i(a_i[0]), .y_i(b_i[0]), .z_i(1'b0), .m_o(g_lo));
    maj3 u_out  (.x_i(a_i[1]), .y_i(b_i[1]), .z_i(g_lo), .m_o(c_out_o));
    assign c_mid_o = g_lo;

    assign exp_c = cla_pair(a_i, b_i, 1'b0);

    always_comb begin
        p_first_hi_r2: assert (c_out_o == exp_c.hi)
            else $error("R2 first pair carry out %b expected %b", c_out_o, exp_c.hi);
        p_first_lo_r3: assert (c_mid_o == exp_c.lo)
            else $error("R3 first pair mid carry %b expected %b", c_mid_o, exp_c.lo);
    end
endmodule

// File: rtl/maj_pair_stage.sv
`timescale 1ns/1ps
module maj_pair_stage
    import maj_adder_pkg::*;
(
    input  logic [1:0] a_i,
    input  logic [1:0] b_i,
    input  logic       c_in_i,
    output logic       c_mid_o,
    output logic       c_out_o
);
    gp_t         lo;
    logic        t_g;
    logic        t_p;
    pair_carry_t exp_c;

    maj3 u_g_lo (.x_i(a_i[0]), .y_i(b_i[0]), .z_i(1'b0), .m_o(lo.g));
    maj3 u_p_lo (.x_i(a_i[0]), .y_i(b_i[0]), .z_i(1'b1), .m_o(lo.p));

    // intermediate carry into the odd bit
    maj3 u_mid  (.x_i(lo.p), .y_i(lo.g), .z_i(c_in_i), .m_o(c_mid_o));

    // nested terms, then a single gate carries c_in across two positions
    maj3 u_hg   (.x_i(a_i[1]), .y_i(b_i[1]), .z_i(lo.g), .m_o(t_g));
    maj3 u_hp   (.x_i(a_i[1]), .y_i(b_i[1]), .z_i(lo.p), .m_o(t_p));
    maj3 u_out  (.x_i(t_g), .y_i(t_p), .z_i(c_in_i), .m_o(c_out_o));

    assign exp_c = cla_pair(a_i, b_i, c_in_i);

    always_comb begin
        p_pair_hi_r2: assert (c_out_o == exp_c.hi)
            else $error("R2 pair carry out %b expected %b", c_out_o, exp_c.hi);
        p_pair_lo_r3: assert (c_mid_o == exp_c.lo)
            else $error("R3 pair mid carry %b expected %b", c_mid_o, exp_c.lo);
    end
endmodule

// File: rtl/maj_sum_cell.sv
`timescale 1ns/1ps
module maj_sum_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_in_i,
    input  logic c_out_i,
    output logic s_o
);
    logic c_out_n;
    logic t;

    assign c_out_n = ~c_out_i;
    maj3 u_t   (.x_i(a_i), .y_i(b_i), .z_i(c_out_n), .m_o(t));
    maj3 u_sum (.x_i(c_out_n), .y_i(c_in_i), .z_i(t), .m_o(s_o));

    always_comb begin
        p_sum_parity_r4: assert (s_o == (a_i ^ b_i ^ c_in_i))
            else $error("R4 sum bit %b expected %b", s_o, a_i ^ b_i ^ c_in_i);
    end
endmodule

// File: rtl/maj_pair_adder.sv
`timescale 1ns/1ps
module maj_pair_adder
    import maj_adder_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [N-1:0] sum_o,
    output logic         carry_o
);
    localparam int unsigned PAIRS = N / 2;

    logic [N:0] carry_w;

    if (!width_ok(N)) begin : g_bad_width
        $error("maj_pair_adder: N must be even and at least 2");
    end

    assign carry_w[0] = 1'b0;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        if (k == 0) begin : g_low
            maj_pair_first u_first (
                .a_i     (op_a[1:0]),
                .b_i     (op_b[1:0]),
                .c_mid_o (carry_w[1]),
                .c_out_o (carry_w[2])
            );
        end else begin : g_mid
            maj_pair_stage u_stage (
                .a_i     (op_a[2*k+1 : 2*k]),
                .b_i     (op_b[2*k+1 : 2*k]),
                .c_in_i  (carry_w[2*k]),
                .c_mid_o (carry_w[2*k+1]),
                .c_out_o (carry_w[2*k+2])
            );
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_sum
        maj_sum_cell u_sum (
            .a_i     (op_a[i]),
            .b_i     (op_b[i]),
            .c_in_i  (carry_w[i]),
            .c_out_i (carry_w[i+1]),
            .s_o     (sum_o[i])
        );
    end

    assign carry_o = carry_w[N];

    always_comb begin
        p_total_sum_r1: assert ({carry_o, sum_o} == ({1'b0, op_a} + {1'b0, op_b}))
            else $error("R1 result mismatch");
    end
endmodule

// File: tb/test_maj_pair_adder.sv
`timescale 1ns/1ps
module test_maj_pair_adder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;

    logic [3:0]  a4 = '0, b4 = '0, s4;
    logic [7:0]  a8 = '0, b8 = '0, s8;
    logic [31:0] a32 = '0, b32 = '0, s32;
    logic        c4, c8, c32;

    typedef struct {
        logic [4:0]  e4;
        logic [8:0]  e8;
        logic [32:0] e32;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    maj_pair_adder #(.N(4)) i_maj_pair_adder_w4 (
        .op_a(a4), .op_b(b4), .sum_o(s4), .carry_o(c4));
    maj_pair_adder #(.N(8)) i_maj_pair_adder_w8 (
        .op_a(a8), .op_b(b8), .sum_o(s8), .carry_o(c8));
    maj_pair_adder i_maj_pair_adder (
        .op_a(a32), .op_b(b32), .sum_o(s32), .carry_o(c32));

    task automatic check(input string req, input string what,
                         input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] x4, input logic [3:0] y4,
                         input logic [7:0] x8, input logic [7:0] y8,
                         input logic [31:0] x32, input logic [31:0] y32,
                         input logic [4:0] e4, input logic [8:0] e8,
                         input logic [32:0] e32, input string req);
        item_t it;
        @(posedge clk);
        a4 = x4; b4 = y4; a8 = x8; b8 = y8; a32 = x32; b32 = y32;
        it.e4 = e4; it.e8 = e8; it.e32 = e32; it.req = req;
        sb_q.push_back(it);
    endtask

    // monitor: compares the oldest expected item half a cycle after driving
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (!rst && sb_q.size() != 0) begin
                it = sb_q.pop_front();
                check(it.req, "w4",  {28'd0, c4, s4},  {28'd0, it.e4});
                check(it.req, "w8",  {24'd0, c8, s8},  {24'd0, it.e8});
                check(it.req, "w32", {c32, s32}, it.e32);
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r1, r2;
        repeat (4) @(posedge clk);
        rst = 1'b0;

        // R5: zero operands, zero carry-in
        drive(4'h0, 4'h0, 8'h00, 8'h00, 32'h0, 32'h0, 5'h00, 9'h000, 33'h0, "R5");

        // R8: worked 4-bit vector 0101 + 0010
        drive(4'h5, 4'h2, 8'h05, 8'h02, 32'h5, 32'h2, 5'b00111, 9'h007, 33'h7, "R8");

        // R6: carry born at bit 0 runs to the top
        drive(4'hF, 4'h1, 8'hFF, 8'h01, 32'hFFFF_FFFF, 32'h1,
              5'h10, 9'h100, 33'h1_0000_0000, "R6");

        // R7: all-ones plus all-ones
        drive(4'hF, 4'hF, 8'hFF, 8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
              5'h1E, 9'h1FE, 33'h1_FFFF_FFFE, "R7");

        // R4: non-overlapping ones, no carries anywhere
        drive(4'h5, 4'hA, 8'h55, 8'hAA, 32'h5555_5555, 32'hAAAA_AAAA,
              5'h0F, 9'h0FF, 33'h0_FFFF_FFFF, "R4");
        drive(4'h3, 4'hC, 8'h0F, 8'hF0, 32'h0F0F_0F0F, 32'hF0F0_F0F0,
              5'h0F, 9'h0FF, 33'h0_FFFF_FFFF, "R4");

        // R2: a lone generate walked across every position
        for (int j = 0; j < 32; j++) begin
            drive(4'(1 << (j % 4)), 4'(1 << (j % 4)),
                  8'(1 << (j % 8)), 8'(1 << (j % 8)),
                  32'(64'(1) << j), 32'(64'(1) << j),
                  5'(1) << (j % 4 + 1), 9'(1) << (j % 8 + 1),
                  33'(1) << (j + 1), "R2");
        end

        // R3: all-ones plus a single one at each position
        for (int j = 0; j < 32; j++) begin
            drive(4'hF, 4'(1 << (j % 4)),
                  8'hFF, 8'(1 << (j % 8)),
                  32'hFFFF_FFFF, 32'(64'(1) << j),
                  {1'b1, 4'((1 << (j % 4)) - 1)},
                  {1'b1, 8'((1 << (j % 8)) - 1)},
                  {1'b1, 32'((64'(1) << j) - 1)}, "R3");
        end

        // R1: every pair at widths 4 and 8, random pairs at width 32
        for (int i = 0; i < 65536; i++) begin
            r1 = $urandom;
            r2 = $urandom;
            drive(4'(i >> 4), 4'(i), 8'(i >> 8), 8'(i),
                  r1, r2,
                  5'({1'b0, 4'(i >> 4)} + {1'b0, 4'(i)}),
                  9'({1'b0, 8'(i >> 8)} + {1'b0, 8'(i)}),
                  {1'b0, r1} + {1'b0, r2}, "R1");
        end

        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule